// File: doc/BRIEF.md
# Flash Command Front End with Status Register

This block models the command side of a byte-wide parallel NOR flash. A bus write is latched when chip-enable and write-enable are both low at a rising clock edge. Single-cycle commands pick the read source (array or status) or clear the error flags. Two-cycle commands (program setup then data, or erase setup then confirm) hand a job to an internal write engine. The engine alters a small internal array. A program clears bits only. An erase fills one block with 0xFF, one byte per cycle.

An 8-bit status byte reports engine readiness and three sticky error flags. One flag marks a programming-voltage fault. While that flag is set, every new job is refused until software clears the flags.

The active-low reset/power-down pin aborts a running job and leaves the array partly changed. It returns the status and read mode to their initial values. While it is low, every control input is ignored. A low-supply lockout input forces array reads and blocks command writes.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: While `rst_pin_n` is low and after it rises, `rd_status` is 0. A status read then returns 0x80. The status byte layout is: bit 7 = ready, bit 5 = erase error, bit 4 = program error, bit 3 = voltage fault, all other bits 0.
- R2: A command is taken only at a rising edge where `ce_n` and `we_n` are both low. With either one high, the read mode does not change.
- R3: Code 0xFF selects array reads (`rd_status`=0) and code 0x70 selects status reads (`rd_status`=1). Any code not listed in these requirements leaves the read mode unchanged.
- R4: Code 0x40 followed by a data write at address A starts a byte program. The byte becomes old AND data. Status bit 7 reads 0 for exactly PROG_CYC cycles.
- R5: Code 0x20 followed by 0xD0 at any address inside a block starts an erase. All 2**BLK_W bytes of that block become 0xFF, and other blocks keep their contents. Bit 7 reads 0 for exactly 2**BLK_W cycles.
- R6: If any second cycle other than 0xD0 follows an erase setup, bits 5 and 4 are set and the array is unchanged.
- R7: If `vpp_ok` is low when a job is confirmed, or while a job runs, the job stops or never starts. Bit 3 is set, together with bit 4 (program) or bit 5 (erase). A stopped erase keeps the bytes it had already erased.
- R8: While bit 3 is set, program and erase confirms are refused: they set their error bit and the array does not change. Code 0x50 clears bits 5, 4 and 3, after which jobs run again.
- R9: Pulling `rst_pin_n` low during a job aborts it. The array is left partly changed, and status and read mode return to their R1 values. Writes issued while the pin is low have no effect.
- R10: While `lockout` is high, reads come from the array and command writes are ignored.
- R11: Setup codes 0x40 and 0x20 switch reads to status. After a job ends, reads stay on status until 0xFF is written, and changes of `vpp_ok` do not alter the read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_pin_n | input | 1 | Reset/power-down, active low, asynchronous |
| lockout | input | 1 | Low-supply lockout |
| vpp_ok | input | 1 | Programming voltage within range |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address for commands and reads |
| din | input | 8 | Command or data byte |
| dout | output | 8 | Array byte or status byte |
| rd_status | output | 1 | 1 when reads return the status byte |

## Verification
The bench uses the defaults: ADDR_W=6, BLK_W=4 and PROG_CYC=4. That gives a 64-byte array in four 16-byte blocks. With this size, every byte can be erased, programmed twice with two computed patterns and read back against the AND of those patterns. The job lengths stay short, so the bench can count the exact busy duration. It can also cut an erase by a voltage drop or by the reset pin at a known byte, and then check the bytes on both sides of that cut.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W   = 6,
  parameter int BLK_W    = 4,
  parameter int PROG_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_pin_n,
  input  logic              lockout,
  input  logic              vpp_ok,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              rd_status
);
  localparam int NBYTES    = 1 << ADDR_W;
  localparam int BLK_BYTES = 1 << BLK_W;
  localparam int CNT_MAX   = (PROG_CYC > BLK_BYTES) ? PROG_CYC : BLK_BYTES;
  localparam int CNT_W     = $clog2(CNT_MAX) + 1;
  localparam logic [CNT_W-1:0] PGM_LAST = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERS_LAST = CNT_W'(BLK_BYTES - 1);

  typedef enum logic [1:0] {C_IDLE, C_PGM, C_ERS} cstate_t;

  logic [7:0]        mem [NBYTES];
  cstate_t           cst;
  logic              busy, op_ers, e_pgm, e_ers, e_vpp;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] tgt;
  logic [7:0]        tdat;

  wire cmd_we   = !ce_n && !we_n && !lockout;
  wire go_ok    = vpp_ok && !e_vpp;
  wire wsm_done = busy && vpp_ok && (cnt == (op_ers ? ERS_LAST : PGM_LAST));

  assign dout = rd_status ? {~busy, 1'b0, e_ers, e_pgm, e_vpp, 3'b000} : mem[addr];

  always_ff @(posedge clk or negedge rst_pin_n) begin
    if (!rst_pin_n) begin
      cst <= C_IDLE; rd_status <= 1'b0; busy <= 1'b0; op_ers <= 1'b0;
      e_pgm <= 1'b0; e_ers <= 1'b0; e_vpp <= 1'b0;
      cnt <= '0; tgt <= '0; tdat <= '0;
    end else begin
      if (lockout) begin
        cst <= C_IDLE;
        rd_status <= 1'b0;
      end
      if (busy) begin
        if (!vpp_ok) begin
          busy <= 1'b0;
          e_vpp <= 1'b1;
          if (op_ers) e_ers <= 1'b1;
          else        e_pgm <= 1'b1;
        end else if (wsm_done) busy <= 1'b0;
        else cnt <= cnt + 1'b1;
      end
      if (cmd_we) begin
        if (cst == C_PGM) begin
          cst <= C_IDLE;
          if (go_ok) begin
            busy <= 1'b1; op_ers <= 1'b0; cnt <= '0; tgt <= addr; tdat <= din;
          end else begin
            e_pgm <= 1'b1;
            if (!vpp_ok) e_vpp <= 1'b1;
          end
        end else if (cst == C_ERS) begin
          cst <= C_IDLE;
          if (din != 8'hD0) begin
            e_pgm <= 1'b1; e_ers <= 1'b1;
          end else if (go_ok) begin
            busy <= 1'b1; op_ers <= 1'b1; cnt <= '0; tgt <= addr;
          end else begin
            e_ers <= 1'b1;
            if (!vpp_ok) e_vpp <= 1'b1;
          end
        end else begin
          case (din)
            8'hFF: rd_status <= 1'b0;
            8'h70: rd_status <= 1'b1;
            8'h50: if (!busy) begin e_pgm <= 1'b0; e_ers <= 1'b0; e_vpp <= 1'b0; end
            8'h40: if (!busy) begin cst <= C_PGM; rd_status <= 1'b1; end
            8'h20: if (!busy) begin cst <= C_ERS; rd_status <= 1'b1; end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy && vpp_ok) begin
      if (op_ers) mem[{tgt[ADDR_W-1:BLK_W], cnt[BLK_W-1:0]}] <= 8'hFF;
      else if (cnt == PGM_LAST) mem[tgt] <= mem[tgt] & tdat;
    end
  end

  p_lockout_array_r10: assert property (@(posedge clk) disable iff (!rst_pin_n)
    lockout |=> !rd_status);
  p_bus_idle_keeps_mode_r2: assert property (@(posedge clk) disable iff (!rst_pin_n)
    ((ce_n || we_n) && !lockout) |=> $stable(rd_status));
  p_start_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_pin_n)
    $rose(busy) |-> $past(cmd_we));
  p_vpp_abort_r7: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (busy && !vpp_ok) |=> (!busy && e_vpp));
  p_fault_blocks_start_r8: assert property (@(posedge clk) disable iff (!rst_pin_n)
    (e_vpp && !busy) |=> !busy);
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int ADDR_W = 6, BLK_W = 4, PROG_CYC = 4;
  localparam int NB = 1 << ADDR_W, BB = 1 << BLK_W;

  logic clk = 1'b0, rst_pin_n = 1'b0, lockout = 1'b0, vpp_ok = 1'b1;
  logic ce_n = 1'b1, we_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic rd_status;
  logic [7:0] model [NB];
  int nchk = 0, nfail = 0, n;
  bit done = 0;

  always #5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .PROG_CYC(PROG_CYC)) u_dut (
    .clk(clk), .rst_pin_n(rst_pin_n), .lockout(lockout), .vpp_ok(vpp_ok),
    .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din), .dout(dout), .rd_status(rd_status));

  function automatic logic [7:0] p1(int a); return 8'(a * 37 + 5); endfunction
  function automatic logic [7:0] p2(int a); return ~8'(a * 11); endfunction

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk); addr = ADDR_W'(a); din = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b1; #1;
  endtask

  task automatic wait_ready(output int cyc);
    cyc = 0;
    while (dout[7] == 1'b0 && cyc < 1000) begin @(negedge clk); #1; cyc++; end
  endtask

  task automatic rd_arr(string tag, int a);
    addr = ADDR_W'(a); #1;
    chk(tag, dout, model[a]);
  endtask

  task automatic prog(int a, logic [7:0] d, output int cyc);
    wr(a, 8'h40); wr(a, d); wait_ready(cyc);
    model[a] = model[a] & d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 chk("R1 mode in reset", {7'd0, rd_status}, 8'd0);
    rst_pin_n = 1'b1;
    @(negedge clk); #1 chk("R1 mode after reset", {7'd0, rd_status}, 8'd0);
    wr(0, 8'h70); chk("R1 status after reset", dout, 8'h80);
    wr(0, 8'hFF);

    @(negedge clk); din = 8'h70; ce_n = 1'b0; we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1; we_n = 1'b0;
    @(negedge clk); we_n = 1'b1; #1;
    chk("R2 half-enabled writes ignored", {7'd0, rd_status}, 8'd0);
    wr(0, 8'h70); chk("R3 0x70 selects status", {7'd0, rd_status}, 8'd1);
    wr(0, 8'h13); chk("R3 unknown code keeps status", {7'd0, rd_status}, 8'd1);
    wr(0, 8'hFF); chk("R3 0xFF selects array", {7'd0, rd_status}, 8'd0);
    wr(0, 8'h13); chk("R3 unknown code keeps array", {7'd0, rd_status}, 8'd0);

    for (int b = 0; b < NB / BB; b++) begin
      wr(b * BB, 8'h20); wr(b * BB + 3, 8'hD0); wait_ready(n);
      if (b == 0) chk("R5 erase busy cycles", 8'(n), 8'(BB));
      chk("R5 status after erase", dout, 8'h80);
      for (int i = 0; i < BB; i++) model[b * BB + i] = 8'hFF;
    end
    wr(0, 8'hFF);
    for (int a = 0; a < NB; a++) rd_arr("R5 erased byte", a);

    for (int a = 0; a < NB; a++) begin
      prog(a, p1(a), n);
      if (a == 0) chk("R4 program busy cycles", 8'(n), 8'(PROG_CYC));
    end
    for (int a = 0; a < NB; a++) prog(a, p2(a), n);
    chk("R11 reads stay on status after job", {7'd0, rd_status}, 8'd1);
    chk("R4 status after program", dout, 8'h80);
    wr(0, 8'hFF);
    for (int a = 0; a < NB; a++) rd_arr("R4 AND of two patterns", a);

    wr(2 * BB, 8'h20); chk("R11 setup selects status", {7'd0, rd_status}, 8'd1);
    wr(2 * BB, 8'hD0); wait_ready(n);
    for (int i = 0; i < BB; i++) model[2 * BB + i] = 8'hFF;
    wr(0, 8'hFF);
    for (int a = 0; a < NB; a++) rd_arr("R5 single block erase", a);

    wr(BB, 8'h20); wr(BB, 8'hB0);
    chk("R6 bad confirm status", dout, 8'hB0);
    wr(0, 8'hFF);
    for (int i = 0; i < BB; i++) rd_arr("R6 block untouched", BB + i);
    wr(0, 8'h50); wr(0, 8'h70); chk("R8 clear status", dout, 8'h80);

    vpp_ok = 1'b0;
    wr(5, 8'h40); wr(5, 8'h00);
    chk("R7 program with low voltage", dout, 8'h98);
    vpp_ok = 1'b1;
    wr(5, 8'h20); wr(5, 8'hD0);
    chk("R8 erase refused while fault", dout, 8'hB8);
    wr(0, 8'hFF); rd_arr("R8 byte kept after refusal", 5);
    wr(0, 8'h50); prog(5, 8'h00, n);
    wr(0, 8'hFF); rd_arr("R8 program after clear", 5);

    for (int i = 0; i < 4; i++) prog(2 * BB + i, 8'h00, n);
    wr(2 * BB, 8'h20); wr(2 * BB, 8'hD0);
    @(posedge clk); @(posedge clk); @(negedge clk); vpp_ok = 1'b0;
    @(negedge clk); vpp_ok = 1'b1; #1;
    chk("R7 voltage drop during erase", dout, 8'hA8);
    chk("R11 mode kept across voltage change", {7'd0, rd_status}, 8'd1);
    model[2 * BB] = 8'hFF; model[2 * BB + 1] = 8'hFF;
    wr(0, 8'hFF);
    for (int i = 0; i < 4; i++) rd_arr("R7 partial erase", 2 * BB + i);
    wr(0, 8'h50);

    wr(3 * BB, 8'h20); wr(3 * BB, 8'hD0);
    @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
    rst_pin_n = 1'b0;
    din = 8'h70; ce_n = 1'b0; we_n = 1'b0;
    repeat (2) @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1; rst_pin_n = 1'b1; #1;
    chk("R9 array mode after reset pin", {7'd0, rd_status}, 8'd0);
    for (int i = 0; i < 3; i++) model[3 * BB + i] = 8'hFF;
    for (int i = 0; i < 4; i++) rd_arr("R9 aborted erase partial", 3 * BB + i);
    wr(0, 8'h70); chk("R9 status after reset pin", dout, 8'h80);

    lockout = 1'b1;
    @(negedge clk); #1 chk("R10 lockout forces array", {7'd0, rd_status}, 8'd0);
    wr(0, 8'h70); chk("R10 write ignored in lockout", {7'd0, rd_status}, 8'd0);
    lockout = 1'b0;
    wr(0, 8'h70); chk("R10 writes resume", {7'd0, rd_status}, 8'd1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule